// File: doc/BRIEF.md
# Flash Status Write-Verify Sequencer

This block drives the command sequence that changes the first status byte of a serial NOR flash and leaves the second status byte alone. That second byte holds the quad-enable bit. A careless single-byte write can clear it on some devices. The block sits in front of a byte-level SPI engine. It issues one transaction at a time through a request/done handshake: an opcode, up to two write bytes, and an optional one-byte read. Chip-select timing and bit shifting belong to the engine.

A start pulse latches the requested status-1 value and three configuration inputs:

- **Write mode.** The default is a two-byte status write. Asserting `singleByteWr` selects a one-byte write; it is meant for devices whose quad-enable bit lives somewhere else.
- **Status-2 read support.** `noReadSr2` says the device lacks the status-2 read opcode.
- **Quad state.** `quadOn` says whether quad mode is currently enabled.

The sequencer then takes these steps in order:

1. If needed, it fetches status byte 2.
2. It sends write-enable.
3. It sends the status write.
4. It polls the ready bit, with a bounded number of polls.
5. Where the mode allows, it checks the result by reading it back.
6. It ends with a one-cycle `done` pulse. `err` is valid in the same cycle.

Top module: `sr_write_verify`

## Requirements
- R1: While reset is held and after reset is released with no start, `busy`, `done`, `err` and `xferReq` are all 0.
- R2: In two-byte mode with the status-2 read allowed (`singleByteWr`=0, `noReadSr2`=0), the transactions are:
  - opcode 35h with a one-byte read;
  - opcode 06h with no data;
  - opcode 01h with write length 2, byte 0 being the requested status-1 value and byte 1 being the value just read by 35h;
  - polls;
  - a final 35h read.
  The run ends with `err`=0 when that final read matches the byte written.
- R3: In two-byte mode with `noReadSr2`=1, no 35h transaction is issued and no read-back check is made. Byte 1 of the 01h write is 02h (quad-enable at bit 1) when `quadOn`=1, and 00h otherwise.
- R4: In one-byte mode (`singleByteWr`=1), the 01h write has length 1 and carries the requested value. The byte returned by the final, not-busy 05h poll is compared with the requested value, and `err`=1 on any difference.
- R5: In two-byte mode with the status-2 read allowed, `err`=1 when the 35h read made after the write differs from the status-2 byte that was written.
- R6: After each status write, opcode 05h with a one-byte read is repeated while bit 0 (busy) of the returned byte is 1. The sequence moves on at the first poll that returns bit 0 = 0.
- R7: If `POLL_LIMIT` consecutive polls all return bit 0 = 1, the run ends with `done` and `err`=1 and issues no further transaction.
- R8: Every 01h transaction is immediately preceded by a completed 06h transaction.
- R9: `done` is high for exactly one cycle per run. `err` is never high without `done`.
- R10: A `start` pulse while `busy`=1 is ignored. The running sequence keeps its latched inputs, and no extra run follows.
- R11: Once `xferReq` is raised, it and `xferOp` stay stable until the cycle in which `xferDone` is seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| newSr1 | input | 8 | Requested status byte 1 value |
| singleByteWr | input | 1 | 1 selects the one-byte status write; 0 (default) selects two-byte |
| noReadSr2 | input | 1 | 1 when the device lacks the status-2 read opcode |
| quadOn | input | 1 | Quad mode currently enabled (used to synthesize status byte 2) |
| xferReq | output | 1 | Transaction request to the SPI engine |
| xferOp | output | 8 | Opcode of the requested transaction |
| xferWrLen | output | 2 | Number of data bytes to write (0 to 2) |
| xferWrData0 | output | 8 | First data byte |
| xferWrData1 | output | 8 | Second data byte |
| xferRdEn | output | 1 | 1 when one byte is read after the write phase |
| xferDone | input | 1 | One-cycle pulse: the engine finished the transaction |
| xferRdData | input | 8 | Byte read by the engine, valid with `xferDone` |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Failure indication, valid with `done` |

## Verification
Some properties are checked on every cycle:

- the handshake stays stable while a request is pending;
- a write-enable always precedes a status write;
- the status write length is legal;
- `done` is a one-cycle pulse, and `err` only appears with it;
- the engine stays quiet while idle.

Other behaviour depends on the sequence as a whole, so only the bench's scenarios can show it:

- the exact order of opcodes for each mode;
- whether status byte 2 is preserved or synthesized;
- the read-back comparison for each mode;
- the poll timeout count;
- whether a start during a run is dropped.

// File: rtl/srw_pkg.sv
package srw_pkg;

  localparam logic [7:0] OPC_RD_S1 = 8'h05;
  localparam logic [7:0] OPC_RD_S2 = 8'h35;
  localparam logic [7:0] OPC_WR_S  = 8'h01;
  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] QE_BYTE   = 8'h02;

  typedef enum logic [2:0] {
    XK_NONE,
    XK_RD2,
    XK_WREN,
    XK_WRS,
    XK_POLL
  } xfer_kind_e;

  typedef struct packed {
    xfer_kind_e kind;
    logic       latchCfg;
    logic       grabSr2;
    logic       pollClr;
    logic       pollInc;
    logic       setFail;
  } ctl_strb_t;

  typedef struct packed {
    logic twoByte;
    logic useRd2;
    logic rdBusy;
    logic pollLast;
    logic rdEqSr1;
    logic rdEqSr2;
    logic failed;
  } dp_stat_t;

endpackage

// File: rtl/srw_datapath.sv
module srw_datapath
  import srw_pkg::*;
#(
  parameter int POLL_LIMIT = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctl_strb_t  strb,
  input  logic [7:0] newSr1,
  input  logic       singleByteWr,
  input  logic       noReadSr2,
  input  logic       quadOn,
  input  logic [7:0] xferRdData,
  output dp_stat_t   stat,
  output logic [7:0] xferOp,
  output logic [1:0] xferWrLen,
  output logic [7:0] xferWrData0,
  output logic [7:0] xferWrData1,
  output logic       xferRdEn
);

  localparam int CNT_W = (POLL_LIMIT > 2) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(POLL_LIMIT - 1);

  logic [7:0]       sr1Q;
  logic [7:0]       sr2Q;
  logic             twoQ;
  logic             noRdQ;
  logic [CNT_W-1:0] cntQ;
  logic             failQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sr1Q  <= '0;
      sr2Q  <= '0;
      twoQ  <= 1'b1;
      noRdQ <= 1'b0;
      cntQ  <= '0;
      failQ <= 1'b0;
    end else begin
      if (strb.latchCfg) begin
        sr1Q  <= newSr1;
        twoQ  <= !singleByteWr;
        noRdQ <= noReadSr2;
        sr2Q  <= (!singleByteWr && noReadSr2 && quadOn) ? QE_BYTE : 8'h00;
        failQ <= 1'b0;
      end
      if (strb.grabSr2) sr2Q <= xferRdData;
      if (strb.pollClr)      cntQ <= '0;
      else if (strb.pollInc) cntQ <= cntQ + 1'b1;
      if (strb.setFail) failQ <= 1'b1;
    end
  end

  always_comb begin
    stat.twoByte  = twoQ;
    stat.useRd2   = twoQ && !noRdQ;
    stat.rdBusy   = xferRdData[0];
    stat.pollLast = (cntQ == CNT_LAST);
    stat.rdEqSr1  = (xferRdData == sr1Q);
    stat.rdEqSr2  = (xferRdData == sr2Q);
    stat.failed   = failQ;
  end

  always_comb begin
    xferOp      = 8'h00;
    xferWrLen   = 2'd0;
    xferWrData0 = 8'h00;
    xferWrData1 = 8'h00;
    xferRdEn    = 1'b0;
    case (strb.kind)
      XK_RD2: begin
        xferOp   = OPC_RD_S2;
        xferRdEn = 1'b1;
      end
      XK_WREN: xferOp = OPC_WREN;
      XK_WRS: begin
        xferOp      = OPC_WR_S;
        xferWrLen   = twoQ ? 2'd2 : 2'd1;
        xferWrData0 = sr1Q;
        xferWrData1 = twoQ ? sr2Q : 8'h00;
      end
      XK_POLL: begin
        xferOp   = OPC_RD_S1;
        xferRdEn = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/srw_control.sv
module srw_control
  import srw_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      singleByteWr,
  input  logic      noReadSr2,
  input  logic      xferDone,
  input  dp_stat_t  stat,
  output ctl_strb_t strb,
  output logic      xferReq,
  output logic      busy,
  output logic      done,
  output logic      err
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD2,
    ST_WREN,
    ST_WRS,
    ST_POLL,
    ST_CHK2,
    ST_FIN
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    strb.kind = XK_NONE;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          strb.latchCfg = 1'b1;
          stateD = (!singleByteWr && !noReadSr2) ? ST_RD2 : ST_WREN;
        end
      end
      ST_RD2: begin
        strb.kind = XK_RD2;
        if (xferDone) begin
          strb.grabSr2 = 1'b1;
          stateD = ST_WREN;
        end
      end
      ST_WREN: begin
        strb.kind = XK_WREN;
        if (xferDone) stateD = ST_WRS;
      end
      ST_WRS: begin
        strb.kind = XK_WRS;
        if (xferDone) begin
          strb.pollClr = 1'b1;
          stateD = ST_POLL;
        end
      end
      ST_POLL: begin
        strb.kind = XK_POLL;
        if (xferDone) begin
          if (stat.rdBusy) begin
            if (stat.pollLast) begin
              strb.setFail = 1'b1;
              stateD = ST_FIN;
            end else begin
              strb.pollInc = 1'b1;
            end
          end else begin
            if (!stat.twoByte && !stat.rdEqSr1) strb.setFail = 1'b1;
            stateD = stat.useRd2 ? ST_CHK2 : ST_FIN;
          end
        end
      end
      ST_CHK2: begin
        strb.kind = XK_RD2;
        if (xferDone) begin
          if (!stat.rdEqSr2) strb.setFail = 1'b1;
          stateD = ST_FIN;
        end
      end
      ST_FIN: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_comb begin
    xferReq = (stateQ == ST_RD2) || (stateQ == ST_WREN) || (stateQ == ST_WRS) ||
              (stateQ == ST_POLL) || (stateQ == ST_CHK2);
    busy = (stateQ != ST_IDLE);
    done = (stateQ == ST_FIN);
    err  = done && stat.failed;
  end

endmodule

// File: rtl/sr_write_verify.sv
module sr_write_verify
  import srw_pkg::*;
#(
  parameter int POLL_LIMIT = 65536
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] newSr1,
  input  logic       singleByteWr,
  input  logic       noReadSr2,
  input  logic       quadOn,
  output logic       xferReq,
  output logic [7:0] xferOp,
  output logic [1:0] xferWrLen,
  output logic [7:0] xferWrData0,
  output logic [7:0] xferWrData1,
  output logic       xferRdEn,
  input  logic       xferDone,
  input  logic [7:0] xferRdData,
  output logic       busy,
  output logic       done,
  output logic       err
);

  ctl_strb_t strb;
  dp_stat_t  stat;

  srw_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .singleByteWr (singleByteWr),
    .noReadSr2    (noReadSr2),
    .xferDone     (xferDone),
    .stat         (stat),
    .strb         (strb),
    .xferReq      (xferReq),
    .busy         (busy),
    .done         (done),
    .err          (err)
  );

  srw_datapath #(.POLL_LIMIT(POLL_LIMIT)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .newSr1       (newSr1),
    .singleByteWr (singleByteWr),
    .noReadSr2    (noReadSr2),
    .quadOn       (quadOn),
    .xferRdData   (xferRdData),
    .stat         (stat),
    .xferOp       (xferOp),
    .xferWrLen    (xferWrLen),
    .xferWrData0  (xferWrData0),
    .xferWrData1  (xferWrData1),
    .xferRdEn     (xferRdEn)
  );

endmodule

// File: rtl/sr_write_verify_chk.sv
module sr_write_verify_chk (
  input logic       clk,
  input logic       rstN,
  input logic       xferReq,
  input logic [7:0] xferOp,
  input logic [1:0] xferWrLen,
  input logic       xferDone,
  input logic       busy,
  input logic       done,
  input logic       err
);

  logic [7:0] lastOp;

  always_ff @(posedge clk) begin
    if (!rstN)         lastOp <= 8'h00;
    else if (xferDone) lastOp <= xferOp;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!xferReq && !done));

  a_r4_write_len_legal: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferOp == 8'h01) |-> (xferWrLen == 2'd1 || xferWrLen == 2'd2));

  a_r8_wren_first: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferOp == 8'h01) |-> (lastOp == 8'h06));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    err |-> done);

  a_r11_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !xferDone) |=> (xferReq && $stable(xferOp)));

endmodule

bind sr_write_verify sr_write_verify_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .xferReq   (xferReq),
  .xferOp    (xferOp),
  .xferWrLen (xferWrLen),
  .xferDone  (xferDone),
  .busy      (busy),
  .done      (done),
  .err       (err)
);

// File: tb/tb_sr_write_verify.sv
module tb_sr_write_verify;

  localparam int CLK_PERIOD = 10;
  localparam int POLL_N     = 4;
  localparam int WDOG       = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] newSr1 = 8'h00;
  logic       singleByteWr = 1'b0;
  logic       noReadSr2 = 1'b0;
  logic       quadOn = 1'b0;
  logic       xferReq;
  logic [7:0] xferOp;
  logic [1:0] xferWrLen;
  logic [7:0] xferWrData0;
  logic [7:0] xferWrData1;
  logic       xferRdEn;
  logic       xferDone = 1'b0;
  logic [7:0] xferRdData = 8'h00;
  logic       busy;
  logic       done;
  logic       err;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [7:0] op;
    logic [1:0] len;
    logic [7:0] d0;
    logic [7:0] d1;
    logic       rd;
    logic [7:0] resp;
    string      tag;
  } item_t;

  item_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_write_verify #(.POLL_LIMIT(POLL_N)) dut (
    .clk(clk), .rstN(rstN), .start(start), .newSr1(newSr1),
    .singleByteWr(singleByteWr), .noReadSr2(noReadSr2), .quadOn(quadOn),
    .xferReq(xferReq), .xferOp(xferOp), .xferWrLen(xferWrLen),
    .xferWrData0(xferWrData0), .xferWrData1(xferWrData1), .xferRdEn(xferRdEn),
    .xferDone(xferDone), .xferRdData(xferRdData),
    .busy(busy), .done(done), .err(err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] op, input logic [1:0] len,
                      input logic [7:0] d0, input logic [7:0] d1,
                      input logic rd, input logic [7:0] resp, input string tag);
    item_t it;
    it.op = op; it.len = len; it.d0 = d0; it.d1 = d1;
    it.rd = rd; it.resp = resp; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor / engine model: pops expected transactions and answers them
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (xferReq) begin
        it.resp = 8'h00;
        if (expQ.size() == 0) begin
          chk(1'b0, "R10", "unexpected transaction op", int'(xferOp), 0);
        end else begin
          it = expQ.pop_front();
          chk(xferOp == it.op, it.tag, "opcode", int'(xferOp), int'(it.op));
          chk(xferWrLen == it.len, it.tag, "write length", int'(xferWrLen), int'(it.len));
          if (it.len >= 2'd1)
            chk(xferWrData0 == it.d0, it.tag, "write byte0", int'(xferWrData0), int'(it.d0));
          if (it.len == 2'd2)
            chk(xferWrData1 == it.d1, it.tag, "write byte1", int'(xferWrData1), int'(it.d1));
          chk(xferRdEn == it.rd, it.tag, "read enable", int'(xferRdEn), int'(it.rd));
        end
        repeat (2) @(negedge clk);
        xferRdData = it.resp;
        xferDone   = 1'b1;
        @(negedge clk);
        xferDone   = 1'b0;
        xferRdData = 8'h00;
      end
    end
  end

  task automatic runSeq(input logic [7:0] sr1, input logic single, input logic noRd,
                        input logic quad, input bit expErr, input bit midStart,
                        input string tag);
    int n;
    @(negedge clk);
    newSr1 = sr1; singleByteWr = single; noReadSr2 = noRd; quadOn = quad;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (3) @(negedge clk);
      newSr1 = ~sr1; singleByteWr = ~single;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done, tag, "done seen", int'(done), 1);
    chk(err == expErr, tag, "err at done", int'(err), int'(expErr));
    @(negedge clk);
    chk(!done, "R9", "done longer than one cycle", int'(done), 0);
    chk(expQ.size() == 0, tag, "transactions left unissued", expQ.size(), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!xferReq && !busy, tag, "activity after done", int'(xferReq | busy), 0);
    end
    newSr1 = 8'h00; singleByteWr = 1'b0; noReadSr2 = 1'b0; quadOn = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired act=%0d exp=<%0d", WDOG, WDOG);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !xferReq, "R1", "outputs in reset",
        int'({busy, done, err, xferReq}), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !xferReq, "R1", "outputs idle after reset",
        int'({busy, done, err, xferReq}), 0);

    // R2 + R6: two-byte, status-2 read allowed, one busy poll then ready
    push(8'h35, 2'd0, 8'h00, 8'h00, 1'b1, 8'h42, "R2");
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd2, 8'h1C, 8'h42, 1'b0, 8'h00, "R2");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h1D, "R6");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h1C, "R6");
    push(8'h35, 2'd0, 8'h00, 8'h00, 1'b1, 8'h42, "R2");
    runSeq(8'h1C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

    // R5: status-2 read-back mismatch
    push(8'h35, 2'd0, 8'h00, 8'h00, 1'b1, 8'h02, "R5");
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd2, 8'h80, 8'h02, 1'b0, 8'h00, "R5");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h80, "R6");
    push(8'h35, 2'd0, 8'h00, 8'h00, 1'b1, 8'h00, "R5");
    runSeq(8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R5");

    // R3: no status-2 read, quad on -> synthesized 02h, no verify
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd2, 8'h24, 8'h02, 1'b0, 8'h00, "R3");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h00, "R3");
    runSeq(8'h24, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R3");

    // R3: no status-2 read, quad off -> 00h
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd2, 8'h0C, 8'h00, 1'b0, 8'h00, "R3");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h0C, "R3");
    runSeq(8'h0C, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");

    // R4: one-byte mode, matching read-back after a busy poll
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd1, 8'h3C, 8'h00, 1'b0, 8'h00, "R4");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h3D, "R6");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h3C, "R4");
    runSeq(8'h3C, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R4");

    // R4: one-byte mode, mismatching read-back
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd1, 8'h3C, 8'h00, 1'b0, 8'h00, "R4");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h38, "R4");
    runSeq(8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R4");

    // R7: poll timeout after POLL_N busy polls
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd1, 8'h5A, 8'h00, 1'b0, 8'h00, "R7");
    for (int i = 0; i < POLL_N; i++)
      push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h01, "R7");
    runSeq(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");

    // R10: start pulse during a run with changed inputs is ignored
    push(8'h35, 2'd0, 8'h00, 8'h00, 1'b1, 8'h06, "R10");
    push(8'h06, 2'd0, 8'h00, 8'h00, 1'b0, 8'h00, "R8");
    push(8'h01, 2'd2, 8'h44, 8'h06, 1'b0, 8'h00, "R10");
    push(8'h05, 2'd0, 8'h00, 8'h00, 1'b1, 8'h44, "R10");
    push(8'h35, 2'd0, 8'h00, 8'h00, 1'b1, 8'h06, "R10");
    runSeq(8'h44, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule